// File: doc/BRIEF.md
# Two-Bank Latching Interrupt Controller

This block collects 64 interrupt input lines into two banks of 32 and presents them to a processor as one combined request line. Each bank gives software four 32-bit words: latched event flags, an enable mask, a write-one-to-clear acknowledge, and a live view of the input pins. The inputs are synchronous to `clk`.

Most lines are edge-latched. A rising edge on an enabled line sets that line's event flag, and the flag holds until software acknowledges it. A per-bank parameter marks some lines as level-sensitive. Those lines never latch. They raise a request for as long as they are high and enabled. Enabling a line that is already high does not count as an edge, so it never creates a fresh request for an edge-latched line.

Software reaches the block through a simple synchronous port. Writes take effect at the clock edge where `wr_en` is high. Read data is registered and appears one cycle after `rd_en`.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While reset is held and after it is released, every enable bit, every event flag and the stored previous-input copy are zero, `irq_req` is 0, and `rdata` is 0 until the first read.
- R2: The window is 0x40 bytes. Lines 0–31 decode at base 0x20 and lines 32–63 at base 0x10. Within a base, offset 0x0 reads events, 0x4 reads and writes the enable mask, 0x8 is acknowledge and reads as 0, and 0xC reads line levels. Bit n of a word is line base_bank×32+n. Offsets 0x00–0x0F and 0x30–0x3F read as 0. `rdata` updates on the edge where `rd_en` is high.
- R3: A write to a bank's enable word stores the written value exactly, and reading it back returns that value.
- R4: A 0→1 change on an edge-latched line whose enable bit was already set sets the line's event bit at that clock edge. A rising edge on a disabled line leaves the event bit at 0.
- R5: Writing 1s to a bank's acknowledge word clears the matching event bits. Bits written as 0 leave their event bits unchanged.
- R6: If an edge sets an event bit in the same cycle that acknowledge clears it, the bit ends up set.
- R7: Setting the enable bit of an edge-latched line that is already high neither sets its event bit nor asserts `irq_req`.
- R8: The level word of each bank returns the current input values, whatever the enable mask holds.
- R9: A level-sensitive line (bank 0 bits 20–28 by default) never sets its event bit. It drives `irq_req` combinationally while it is high and enabled.
- R10: `irq_req` is the OR over both banks of ((event | (line & level_mask)) & enable).
- R11: Writes to the event word or the level word change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 64 | Interrupt inputs, line k on bit k |
| addr | input | 6 | Byte address within the register window |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Combined interrupt request |

## Verification
A stuck or wrongly cleared event flag appears on `irq_req` in the cycle after the offending edge or acknowledge. It also appears in the event word two cycles after the stimulus step begins. A previous-input copy that is wrong shows up as a spurious or missing event on the next transition of the line. This is most visible when an enable is written while the line is already high. A decode fault that swaps banks or register offsets shows up on the first read-back of the enable word, or in which bank's event word reports a given line.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    // Register slot within a bank, taken from byte address bits [3:2]
    typedef enum logic [1:0] {
        SEL_EVENT  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_ACK    = 2'd2,
        SEL_LEVEL  = 2'd3
    } reg_sel_e;

    localparam int unsigned SLOT_BYTES = 16;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
    import irq_latch_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic [ADDR_W-1:2]    word_addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output reg_sel_e             sel
);
    localparam int unsigned SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;

    assign slot = word_addr[ADDR_W-1:4];
    assign sel  = reg_sel_e'(word_addr[3:2]);

    // Bank b sits at slot (NUM_BANKS - b); lowest lines take the highest slot
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(NUM_BANKS - b);
        assign bank_hit[b] = (slot == MY_SLOT);
    end

endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int unsigned     LINES    = 32,
    parameter logic [LINES-1:0] LVL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    input  logic             en_we,
    input  logic             ack_we,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] en_q,
    output logic [LINES-1:0] ev_q,
    output logic [LINES-1:0] prev_q,
    output logic             req
);
    localparam logic [LINES-1:0] EDGE_MASK = ~LVL_MASK;

    logic [LINES-1:0] rise;
    logic [LINES-1:0] set_v;
    logic [LINES-1:0] clr_v;
    logic [LINES-1:0] ev_d;

    always_comb begin
        rise  = lines & ~prev_q;
        set_v = rise & en_q & EDGE_MASK;
        clr_v = ack_we ? wdata : '0;
        // a new edge outranks an acknowledge in the same cycle
        ev_d  = (ev_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            ev_q   <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= lines;
            ev_q   <= ev_d;
            if (en_we) begin
                en_q <= wdata;
            end
        end
    end

    assign req = |((ev_q | (lines & LVL_MASK)) & en_q);

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_latch_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned LINES     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [NUM_BANKS-1:0]       bank_hit,
    input  reg_sel_e                   sel,
    input  logic [NUM_BANKS*LINES-1:0] ev_all,
    input  logic [NUM_BANKS*LINES-1:0] en_all,
    input  logic [NUM_BANKS*LINES-1:0] lvl_all,
    output logic [LINES-1:0]           rdata
);
    logic [LINES-1:0] word_d;

    always_comb begin
        word_d = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                unique case (sel)
                    SEL_EVENT:  word_d = ev_all[b*LINES +: LINES];
                    SEL_ENABLE: word_d = en_all[b*LINES +: LINES];
                    SEL_ACK:    word_d = '0;
                    SEL_LEVEL:  word_d = lvl_all[b*LINES +: LINES];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= word_d;
        end
    end

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
    import irq_latch_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned LINES     = 32,
    parameter int unsigned ADDR_W    = 6,
    parameter logic [NUM_BANKS*LINES-1:0] LVL_MASK = 64'h0000_0000_1FF0_0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS*LINES-1:0] irq_lines,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [LINES-1:0]           wdata,
    input  logic                       wr_en,
    input  logic                       rd_en,
    output logic [LINES-1:0]           rdata,
    output logic                       irq_req
);
    localparam int unsigned TOTAL = NUM_BANKS * LINES;

    logic [NUM_BANKS-1:0] bank_hit;
    reg_sel_e             sel;
    logic [TOTAL-1:0]     en_all;
    logic [TOTAL-1:0]     ev_all;
    logic [TOTAL-1:0]     prev_all;
    logic [NUM_BANKS-1:0] bank_req;
    logic                 unused_byte_lane;

    assign unused_byte_lane = ^addr[1:0];

    irq_addr_dec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .word_addr (addr[ADDR_W-1:2]),
        .bank_hit  (bank_hit),
        .sel       (sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic en_we;
        logic ack_we;

        assign en_we  = wr_en & bank_hit[b] & (sel == SEL_ENABLE);
        assign ack_we = wr_en & bank_hit[b] & (sel == SEL_ACK);

        irq_bank #(
            .LINES    (LINES),
            .LVL_MASK (LVL_MASK[b*LINES +: LINES])
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .lines  (irq_lines[b*LINES +: LINES]),
            .en_we  (en_we),
            .ack_we (ack_we),
            .wdata  (wdata),
            .en_q   (en_all[b*LINES +: LINES]),
            .ev_q   (ev_all[b*LINES +: LINES]),
            .prev_q (prev_all[b*LINES +: LINES]),
            .req    (bank_req[b])
        );
    end

    irq_rd_mux #(
        .NUM_BANKS (NUM_BANKS),
        .LINES     (LINES)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .bank_hit (bank_hit),
        .sel      (sel),
        .ev_all   (ev_all),
        .en_all   (en_all),
        .lvl_all  (irq_lines),
        .rdata    (rdata)
    );

    assign irq_req = |bank_req;

endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned LINES     = 32,
    parameter int unsigned ADDR_W    = 6,
    parameter logic [NUM_BANKS*LINES-1:0] LVL_MASK = '0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_BANKS*LINES-1:0] irq_lines,
    input logic [ADDR_W-1:0]          addr,
    input logic [LINES-1:0]           wdata,
    input logic                       wr_en,
    input logic                       irq_req,
    input logic [NUM_BANKS*LINES-1:0] en_all,
    input logic [NUM_BANKS*LINES-1:0] ev_all,
    input logic [NUM_BANKS*LINES-1:0] prev_all
);
    localparam int unsigned TOTAL = NUM_BANKS * LINES;
    localparam logic [ADDR_W-1:0] EN0_ADDR = ADDR_W'(NUM_BANKS * 16 + 4);

    // R10
    no_req_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |-> !irq_req);

    // R4
    no_event_on_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ev_all & ~$past(ev_all) & ~$past(en_all)) == '0));

    // R7
    event_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ev_all & ~$past(ev_all) & ~($past(irq_lines) & ~$past(prev_all))) == '0));

    // R9
    level_never_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_all & LVL_MASK) == TOTAL'(0)));

    // R3
    enable_write_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr[ADDR_W-1:2] == EN0_ADDR[ADDR_W-1:2]))
        |=> (en_all[LINES-1:0] == $past(wdata)));

endmodule

bind irq_latch_ctrl irq_latch_chk #(
    .NUM_BANKS (NUM_BANKS),
    .LINES     (LINES),
    .ADDR_W    (ADDR_W),
    .LVL_MASK  (LVL_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .addr      (addr),
    .wdata     (wdata),
    .wr_en     (wr_en),
    .irq_req   (irq_req),
    .en_all    (en_all),
    .ev_all    (ev_all),
    .prev_all  (prev_all)
);

// File: tb/irq_latch_ctrl_tb.sv
`timescale 1ns/1ps
module irq_latch_ctrl_tb;

    typedef struct packed {
        logic [3:0]  req;
        logic [63:0] lines;
        logic        wr;
        logic [5:0]  waddr;
        logic [31:0] wdata;
        logic [5:0]  raddr;
        logic [31:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    localparam int NVEC = 24;
    // Bank0 (lines 0-31): event 0x20, enable 0x24, ack 0x28, level 0x2C
    // Bank1 (lines 32-63): event 0x10, enable 0x14, ack 0x18, level 0x1C
    localparam vec_t VEC [NVEC] = '{
        '{4'd3,  64'h0,            1'b1, 6'h24, 32'h0000_00FF, 6'h24, 32'h0000_00FF, 1'b0}, // R3
        '{4'd4,  64'h1,            1'b0, 6'h00, 32'h0,         6'h20, 32'h1,         1'b1}, // R4
        '{4'd5,  64'h1,            1'b1, 6'h28, 32'h1,         6'h20, 32'h0,         1'b0}, // R5
        '{4'd4,  64'h101,          1'b0, 6'h00, 32'h0,         6'h20, 32'h0,         1'b0}, // R4 disabled
        '{4'd7,  64'h101,          1'b1, 6'h24, 32'h0000_01FF, 6'h20, 32'h0,         1'b0}, // R7
        '{4'd8,  64'h1,            1'b0, 6'h00, 32'h0,         6'h2C, 32'h1,         1'b0}, // R8
        '{4'd6,  64'h101,          1'b1, 6'h28, 32'h100,       6'h20, 32'h100,       1'b1}, // R6
        '{4'd5,  64'h101,          1'b1, 6'h28, 32'h0,         6'h20, 32'h100,       1'b1}, // R5 zeros
        '{4'd11, 64'h101,          1'b1, 6'h20, 32'hFFFF_FFFF, 6'h20, 32'h100,       1'b1}, // R11
        '{4'd5,  64'h101,          1'b1, 6'h28, 32'h100,       6'h20, 32'h0,         1'b0}, // R5
        '{4'd4,  64'h1_0000_0101,  1'b1, 6'h14, 32'h1,         6'h10, 32'h0,         1'b0}, // R4
        '{4'd8,  64'h101,          1'b0, 6'h00, 32'h0,         6'h1C, 32'h0,         1'b0}, // R8
        '{4'd10, 64'h1_0000_0101,  1'b0, 6'h00, 32'h0,         6'h10, 32'h1,         1'b1}, // R10
        '{4'd2,  64'h1_0000_0101,  1'b0, 6'h00, 32'h0,         6'h20, 32'h0,         1'b1}, // R2
        '{4'd8,  64'h1_0000_0101,  1'b0, 6'h00, 32'h0,         6'h1C, 32'h1,         1'b1}, // R8
        '{4'd5,  64'h1_0000_0101,  1'b1, 6'h18, 32'h1,         6'h10, 32'h0,         1'b0}, // R5
        '{4'd9,  64'h1_0010_0101,  1'b0, 6'h00, 32'h0,         6'h20, 32'h0,         1'b0}, // R9
        '{4'd9,  64'h1_0010_0101,  1'b1, 6'h24, 32'h0010_01FF, 6'h24, 32'h0010_01FF, 1'b1}, // R9
        '{4'd9,  64'h1_0000_0101,  1'b0, 6'h00, 32'h0,         6'h20, 32'h0,         1'b0}, // R9
        '{4'd11, 64'h1_0000_0101,  1'b1, 6'h2C, 32'hFFFF_FFFF, 6'h2C, 32'h101,       1'b0}, // R11
        '{4'd2,  64'h1_0000_0101,  1'b0, 6'h00, 32'h0,         6'h00, 32'h0,         1'b0}, // R2
        '{4'd2,  64'h1_0000_0101,  1'b0, 6'h00, 32'h0,         6'h30, 32'h0,         1'b0}, // R2
        '{4'd2,  64'h1_0000_0101,  1'b0, 6'h00, 32'h0,         6'h28, 32'h0,         1'b0}, // R2
        '{4'd11, 64'h1_0000_0101,  1'b0, 6'h00, 32'h0,         6'h24, 32'h0010_01FF, 1'b0}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_lines = '0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_latch_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .addr      (addr),
        .wdata     (wdata),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .rdata     (rdata),
        .irq_req   (irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One step: drive lines and optional write, then read, then compare
    task automatic run_step(input vec_t v);
        @(negedge clk);
        irq_lines = v.lines;
        wr_en = v.wr;
        addr = v.waddr;
        wdata = v.wdata;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b1;
        addr = v.raddr;
        @(negedge clk);
        rd_en = 1'b0;
        check($sformatf("R%0d rdata @%h", v.req, v.raddr), rdata, v.exp_rd);
        check($sformatf("R%0d irq_req", v.req), {31'b0, irq_req}, {31'b0, v.exp_irq});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata in reset", rdata, 32'h0);
        check("R1 irq_req in reset", {31'b0, irq_req}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run_step(VEC[i]);
        end

        // R2 / R4: top line of bank 1
        run_step('{4'd2, 64'h1_0000_0101, 1'b1, 6'h14, 32'h8000_0001, 6'h14, 32'h8000_0001, 1'b0});
        run_step('{4'd4, 64'h8000_0001_0000_0101, 1'b0, 6'h00, 32'h0, 6'h10, 32'h8000_0000, 1'b1});
        run_step('{4'd5, 64'h8000_0001_0000_0101, 1'b1, 6'h18, 32'h8000_0000, 6'h10, 32'h0, 1'b0});

        // R1: reset in mid-run clears enables and events
        run_step('{4'd6, 64'h8000_0001_0000_0100, 1'b0, 6'h00, 32'h0, 6'h14, 32'h8000_0001, 1'b0});
        run_step('{4'd4, 64'h8000_0001_0000_0101, 1'b0, 6'h00, 32'h0, 6'h20, 32'h1, 1'b1});
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 irq_req after mid-run reset", {31'b0, irq_req}, 32'h0);
        check("R1 rdata after mid-run reset", rdata, 32'h0);
        rst_n = 1'b1;
        run_step('{4'd1, 64'h8000_0001_0000_0101, 1'b0, 6'h00, 32'h0, 6'h24, 32'h0, 1'b0});
        run_step('{4'd1, 64'h8000_0001_0000_0101, 1'b0, 6'h00, 32'h0, 6'h14, 32'h0, 1'b0});
        run_step('{4'd1, 64'h8000_0001_0000_0101, 1'b0, 6'h00, 32'h0, 6'h20, 32'h0, 1'b0});

        finish_run();
    end

endmodule